// File: doc/BRIEF.md
# Balanced-Ternary Cascaded Bridge Switch Encoder

This block turns a signed output-level command for a multilevel inverter into the gate signals of four series-connected H-bridges. The bridges have DC supplies in a 1:3:9:27 ratio, so together they can produce 81 distinct output steps, from -40 through 0 to +40 units. A controller presents a level on a 7-bit two's-complement bus with a one-cycle valid strobe. The encoder limits the value to the reachable span and splits it into one balanced-ternary digit per bridge, each -1, 0 or +1. It then sets each bridge's four switches to source, sink or bypass its supply.

A bypassed bridge has two legal switch states. The encoder picks between them so that leaving an active state toggles only the leg made of switches 3 and 4. A bridge that is already bypassed keeps its current variant. Commands outside the reachable span are clamped and recorded in a sticky error flag.

Top module: `bt_cascade_encoder`

## Requirements
- R1: While reset is held and after its release, every bridge is in the zero state with switches 2 and 4 on (gate_o = 16'hAAAA), and range_err_o is 0.
- R2: Bridge k (k = 0..3, supply weight 3^k) drives gate_o[4k+3:4k], and bit 4k+j is switch j+1 of that bridge.
- R3: A +1 digit turns on switches 1 and 4 only (nibble 4'b1001). A -1 digit turns on switches 2 and 3 only (nibble 4'b0110).
- R4: The digits d3..d0, each in {-1, 0, +1}, satisfy clamped_level = 27*d3 + 9*d2 + 3*d1 + d0. A bridge whose nibble is 4'b1001 counts as +1, one with 4'b0110 counts as -1, and one with 4'b0101 or 4'b1010 counts as 0.
- R5: gate_o changes only on the clock edge at which valid_i is high, and it shows the new state from that edge on. Without valid_i, changes on level_i have no effect on gate_o.
- R6: A level above +40 is treated as +40, and a level below -40 is treated as -40.
- R7: range_err_o goes high on the edge that accepts an out-of-range level. It then stays high, whatever the later commands, until reset.
- R8: A zero digit for a bridge that is already at zero leaves its nibble unchanged.
- R9: A zero digit for a bridge that was at +1 selects switches 1 and 3 (4'b0101). A zero digit for a bridge that was at -1 selects switches 2 and 4 (4'b1010).
- R10: In no bridge are switches 1 and 2 on together, nor switches 3 and 4 on together, in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | Level command strobe |
| level_i | input | 7 | Signed level command, two's complement |
| gate_o | output | 16 | Switch gate bits, four per bridge |
| range_err_o | output | 1 | Sticky out-of-range flag |

## Verification
Clamping and the zero-variant choice can both act on one command. An out-of-range value such as +50 becomes +40, and all four bridges go active. The next command then drives several bridges from +1 to zero in the same edge that must keep the error flag set. The bench issues that sequence and compares each bridge nibble with a model that derives digits greedily from the most significant weight. A per-cycle leg check runs all the while.

// File: rtl/bt_pkg.sv
package bt_pkg;
  localparam int NUM_STAGES = 4;
  localparam int LVL_W      = 7;

  localparam logic [3:0] GATE_POS = 4'b1001;
  localparam logic [3:0] GATE_NEG = 4'b0110;
  localparam logic [3:0] GATE_ZA  = 4'b0101;
  localparam logic [3:0] GATE_ZB  = 4'b1010;

  typedef logic signed [1:0] trit_t;

  function automatic int pow3(input int n);
    int p;
    p = 1;
    for (int i = 0; i < n; i++) p = p * 3;
    return p;
  endfunction
endpackage

// File: rtl/bt_level_clamp.sv
module bt_level_clamp #(
  parameter int STAGES = bt_pkg::NUM_STAGES,
  parameter int LVL_W  = bt_pkg::LVL_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic signed [LVL_W-1:0] level_i,
  output logic signed [LVL_W-1:0] level_o,
  output logic                    oor_o
);
  localparam int MAX_LVL = (bt_pkg::pow3(STAGES) - 1) / 2;
  localparam logic signed [LVL_W-1:0] HI = LVL_W'(MAX_LVL);
  localparam logic signed [LVL_W-1:0] LO = LVL_W'(-MAX_LVL);

  logic above, below;
  assign above = level_i > HI;
  assign below = level_i < LO;
  assign oor_o = above | below;

  always_comb begin
    if (above)      level_o = HI;
    else if (below) level_o = LO;
    else            level_o = level_i;
  end

  AST_CLAMP_SPAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_o <= HI) && (level_o >= LO)); // R6
endmodule

// File: rtl/bt_digit_split.sv
module bt_digit_split #(
  parameter int STAGES = bt_pkg::NUM_STAGES,
  parameter int LVL_W  = bt_pkg::LVL_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic signed [LVL_W-1:0] level_i,
  output logic [2*STAGES-1:0]     digits_o
);
  function automatic logic [2*STAGES-1:0] split(input logic signed [LVL_W-1:0] lvl);
    int v, r;
    logic [2*STAGES-1:0] d;
    v = int'(lvl);
    d = '0;
    for (int k = 0; k < STAGES; k++) begin
      r = v % 3;
      if (r > 1) r = r - 3;
      else if (r < -1) r = r + 3;
      d[2*k +: 2] = r[1:0];
      v = (v - r) / 3;
    end
    return d;
  endfunction

  function automatic int rebuild(input logic [2*STAGES-1:0] d);
    int s, w;
    s = 0;
    w = 1;
    for (int k = 0; k < STAGES; k++) begin
      s = s + int'($signed(d[2*k +: 2])) * w;
      w = w * 3;
    end
    return s;
  endfunction

  assign digits_o = split(level_i);

  AST_DIGIT_SUM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rebuild(digits_o) == int'(level_i)); // R4

  generate
    for (genvar k = 0; k < STAGES; k++) begin : g_legal
      AST_DIGIT_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        digits_o[2*k +: 2] != 2'b10); // R4
    end
  endgenerate
endmodule

// File: rtl/bt_bridge_gate.sv
module bt_bridge_gate (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  bt_pkg::trit_t digit_i,
  output logic [3:0]   gate_o
);
  import bt_pkg::*;

  logic [3:0] gate_q, gate_d;
  logic       at_zero, at_pos;

  assign at_zero = (gate_q == GATE_ZA) || (gate_q == GATE_ZB);
  assign at_pos  = (gate_q == GATE_POS);

  always_comb begin
    gate_d = gate_q;
    if (load_i) begin
      case (digit_i)
        2'sb01:  gate_d = GATE_POS;
        2'sb11:  gate_d = GATE_NEG;
        default: begin
          if (at_zero)     gate_d = gate_q;
          else if (at_pos) gate_d = GATE_ZA;
          else             gate_d = GATE_ZB;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) gate_q <= GATE_ZB;
    else         gate_q <= gate_d;
  end

  assign gate_o = gate_q;

  AST_NO_SHOOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(gate_o[0] && gate_o[1]) && !(gate_o[2] && gate_o[3])); // R10
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(gate_o)); // R5
  AST_ACTIVE_POS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && digit_i == 2'sb01 |=> gate_o == 4'b1001); // R3
  AST_ACTIVE_NEG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && digit_i == 2'sb11 |=> gate_o == 4'b0110); // R3
  AST_ZERO_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && digit_i == 2'sb00 && (gate_o == 4'b0101 || gate_o == 4'b1010)
    |=> $stable(gate_o)); // R8
  AST_POS_TO_ZA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && digit_i == 2'sb00 && gate_o == 4'b1001 |=> gate_o == 4'b0101); // R9
  AST_NEG_TO_ZB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && digit_i == 2'sb00 && gate_o == 4'b0110 |=> gate_o == 4'b1010); // R9
endmodule

// File: rtl/bt_cascade_encoder.sv
module bt_cascade_encoder #(
  parameter int STAGES = bt_pkg::NUM_STAGES,
  parameter int LVL_W  = bt_pkg::LVL_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  input  logic signed [LVL_W-1:0] level_i,
  output logic [4*STAGES-1:0]     gate_o,
  output logic                    range_err_o
);
  logic signed [LVL_W-1:0] lvl_clamped;
  logic                    lvl_oor;
  logic [2*STAGES-1:0]     digits;
  logic                    err_q;

  bt_level_clamp #(.STAGES(STAGES), .LVL_W(LVL_W)) u_clamp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .level_i (level_i),
    .level_o (lvl_clamped),
    .oor_o   (lvl_oor)
  );

  bt_digit_split #(.STAGES(STAGES), .LVL_W(LVL_W)) u_split (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .level_i  (lvl_clamped),
    .digits_o (digits)
  );

  generate
    for (genvar k = 0; k < STAGES; k++) begin : g_bridge
      bt_bridge_gate u_bridge (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .load_i  (valid_i),
        .digit_i (digits[2*k +: 2]),
        .gate_o  (gate_o[4*k +: 4])
      );
    end
  endgenerate

  always_ff @(posedge clk_i) begin
    if (!rst_ni)                err_q <= 1'b0;
    else if (valid_i && lvl_oor) err_q <= 1'b1;
  end

  assign range_err_o = err_q;

  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    range_err_o |=> range_err_o); // R7
  AST_ERR_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && lvl_oor |=> range_err_o); // R7
endmodule

// File: tb/bt_cascade_encoder_tb.sv
module bt_cascade_encoder_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 15;
  localparam logic signed [6:0] TBL_LVL [NV] =
    '{7'sd0, 7'sd1, 7'sd2, -7'sd1, 7'sd4, 7'sd13, -7'sd13, 7'sd40,
      -7'sd40, 7'sd20, -7'sd20, 7'sd27, -7'sd27, 7'sd3, 7'sd0};
  localparam int TBL_EXP [NV] =
    '{0, 1, 2, -1, 4, 13, -13, 40, -40, 20, -20, 27, -27, 3, 0};

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              valid = 1'b0;
  logic signed [6:0] level = '0;
  logic [15:0]       gate;
  logic              err;
  logic [15:0]       model = 16'hAAAA;
  int                n_chk = 0;
  int                n_bad = 0;
  bit                done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bt_cascade_encoder dut_i (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .level_i(level),
    .gate_o(gate), .range_err_o(err)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] next_model(input int lvl, input logic [15:0] prev);
    int rem, w, d;
    logic [15:0] g;
    logic [3:0] p;
    rem = (lvl > 40) ? 40 : (lvl < -40) ? -40 : lvl;
    g = prev;
    for (int k = 3; k >= 0; k--) begin
      w = 1;
      for (int i = 0; i < k; i++) w = w * 3;
      d = (rem > (w - 1) / 2) ? 1 : (rem < -(w - 1) / 2) ? -1 : 0;
      rem = rem - d * w;
      p = prev[4*k +: 4];
      if (d == 1)       g[4*k +: 4] = 4'b1001;
      else if (d == -1) g[4*k +: 4] = 4'b0110;
      else if (p == 4'b1001) g[4*k +: 4] = 4'b0101;
      else if (p == 4'b0110) g[4*k +: 4] = 4'b1010;
      else g[4*k +: 4] = p;
    end
    return g;
  endfunction

  function automatic int decode(input logic [15:0] g);
    int s, w;
    s = 0;
    w = 1;
    for (int k = 0; k < 4; k++) begin
      if (g[4*k +: 4] == 4'b1001) s = s + w;
      else if (g[4*k +: 4] == 4'b0110) s = s - w;
      else if (g[4*k +: 4] != 4'b0101 && g[4*k +: 4] != 4'b1010) s = s + 1000;
      w = w * 3;
    end
    return s;
  endfunction

  task automatic apply(input logic signed [6:0] v);
    @(negedge clk);
    level = v;
    valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
    model = next_model(int'(v), model);
  endtask

  // R10: leg check every cycle
  always @(negedge clk) begin
    if (rst_n) begin
      for (int k = 0; k < 4; k++) begin
        n_chk++;
        if ((gate[4*k] && gate[4*k+1]) || (gate[4*k+2] && gate[4*k+3])) begin
          n_bad++;
          $display("FAIL R10 bridge %0d actual=%0h expected=no shared leg", k, gate[4*k +: 4]);
        end
      end
    end
  end

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 gates in reset", int'(gate), 16'hAAAA);
    chk("R1 err in reset", int'(err), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 gates after reset", int'(gate), 16'hAAAA);
    chk("R1 err after reset", int'(err), 0);

    for (int i = 0; i < NV; i++) begin
      apply(TBL_LVL[i]);
      chk("R3 R2 gates vs model", int'(gate), int'(model));
      chk("R4 decoded level", decode(gate), TBL_EXP[i]);
      chk("R7 no error in range", int'(err), 0);
    end

    // R5: level changes without valid are ignored
    apply(7'sd13);
    @(negedge clk);
    level = -7'sd13;
    repeat (3) @(negedge clk);
    chk("R5 hold without valid", int'(gate), int'(model));

    // R9 / R8 on bridge 0
    apply(7'sd1);
    chk("R3 bridge0 positive", int'(gate[3:0]), 4'b1001);
    apply(7'sd0);
    chk("R9 pos to zero A", int'(gate[3:0]), 4'b0101);
    apply(7'sd0);
    chk("R8 zero keeps A", int'(gate[3:0]), 4'b0101);
    apply(-7'sd1);
    chk("R3 bridge0 negative", int'(gate[3:0]), 4'b0110);
    apply(7'sd0);
    chk("R9 neg to zero B", int'(gate[3:0]), 4'b1010);
    apply(7'sd9);
    chk("R2 bridge2 active only", int'(gate), int'(model));
    chk("R2 bridge2 nibble", int'(gate[11:8]), 4'b1001);

    // R6 / R7 clamping and sticky flag
    apply(7'sd41);
    chk("R6 clamp +41", int'(gate), 16'h9999);
    chk("R7 err set", int'(err), 1);
    apply(7'sd0);
    chk("R9 all pos to zero A", int'(gate), 16'h5555);
    chk("R7 err sticky", int'(err), 1);
    apply(7'sd50);
    chk("R6 clamp +50", decode(gate), 40);
    apply(-7'sd64);
    chk("R6 clamp -64", int'(gate), 16'h6666);
    apply(-7'sd41);
    chk("R6 clamp -41", decode(gate), -40);
    apply(7'sd5);
    chk("R4 level 5 after clamp", int'(gate), int'(model));
    chk("R7 err still set", int'(err), 1);

    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 err cleared by reset", int'(err), 0);
    chk("R1 gates after second reset", int'(gate), 16'hAAAA);

    done = 1'b1;
    finish_run();
  end
endmodule